// File: doc/BRIEF.md
# Masked Interrupt Encoder

This block gathers sixteen level-sensitive interrupt lines from local-bus peripherals into a single request line for the processor. Each line is sampled into its own bit of a source register on every clock. A bit is set while its line is high and cleared once the line drops. A software-owned enable mask selects which of those bits may raise the combined request. The request line is high whenever at least one enabled source is pending.

Software services the request through a small register port that uses 16-bit accesses only. Reading the vector register returns a ready-to-use code for the lowest-numbered pending enabled source: the index plus one, shifted left by two, or zero when nothing is pending. This lets a handler jump through a table without scanning bits itself. The mask register can be read back and rewritten at any time. A new mask acts on the request line at the next clock.

Top module: `irq_vector_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask reads 0x0010, every source bit is clear, irq_out is low and the vector register reads 0.
- R2: Source bit i equals the level that irq_lvl[i] had at the previous rising clock edge, so a line that falls clears its bit one clock later.
- R3: irq_out is high exactly when the registered sources ANDed with the registered mask are nonzero, and it changes one clock after the input that caused the change.
- R4: A read at offset 0x000 returns (k+1)*4 in the low bits of rdata, where k is the lowest-numbered source that is both set and enabled; the remaining bits are zero.
- R5: A read at offset 0x000 returns 0 when no enabled source is pending, including when sources are set but masked off.
- R6: A write with wr_en high at offset 0x002 loads wdata into the mask; the new mask reads back from offset 0x002 and governs irq_out from the next clock on.
- R7: Writes to any offset other than 0x002, including odd offsets, leave the mask unchanged.
- R8: Reads at any offset other than 0x000 and 0x002 return 0.
- R9: When several enabled sources are pending, the vector names the lowest index, whatever higher sources are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lvl | input | 16 | Interrupt request levels, one per source |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe for one 16-bit access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current offset (combinational from registered state) |
| irq_out | output | 1 | Combined request, high while any enabled source is pending |

## Verification
The assertions assume that irq_lvl is already synchronous to clk. They also assume that a write is a single 16-bit access presented together with its offset in the cycle where wr_en is high. The bench changes irq_lvl, addr, wr_en and wdata only on the falling clock edge, so every input is stable across the rising edge that samples it. Its random phase chooses offsets from valid, unused and odd values, so the mask-hold properties see writes that must be ignored as well as writes that land.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Package irq_pkg
// Shared constants for the masked interrupt encoder: register offsets,
// reset mask and vector scaling. Assumes byte offsets and 16-bit accesses.
package irq_pkg;
    // Byte offset of the encoded vector register (read only)
    localparam int unsigned OFS_VEC   = 0;
    // Byte offset of the enable mask register (read/write)
    localparam int unsigned OFS_MASK  = 2;
    // Mask value loaded by reset
    localparam logic [15:0] MASK_RESET = 16'h0010;
    // Left shift applied to (index + 1) to form the vector code
    localparam int unsigned VEC_SHIFT = 2;
endpackage

// File: rtl/irq_src_capture.sv
`timescale 1ns/1ps
// Module irq_src_capture
// Samples the interrupt request levels into the source register once per
// clock. Each bit follows its line: set while high, cleared when low.
// Assumes irq_lvl is synchronous to clk.
module irq_src_capture #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_lvl,
    output logic [N_SRC-1:0] src_q
);

    // Per-bit level capture, one flop per source
    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) src_q[g] <= 1'b0;
                else        src_q[g] <= irq_lvl[g];
            end
        end
    endgenerate

    // R2: each source bit carries the level its line had one clock earlier
    a_r2_src_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (src_q == $past(irq_lvl)));

endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
// Module irq_mask_reg
// Holds the software enable mask. Decodes register-port writes: only a
// write at the mask offset loads the mask, everything else is ignored.
// Exposes the next-state mask so the output flop can track it.
module irq_mask_reg #(
    parameter int          N_SRC      = 16,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 12,
    parameter logic [15:0] MASK_RESET = irq_pkg::MASK_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  mask_nxt
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(irq_pkg::OFS_MASK);

    logic hit_wr;

    // Write decode: exact match on the mask offset
    always_comb begin
        hit_wr   = wr_en && (addr == A_MASK);
        mask_nxt = hit_wr ? wdata[N_SRC-1:0] : mask_q;
    end

    // Mask storage with reset value
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RESET[N_SRC-1:0];
        else        mask_q <= mask_nxt;
    end

    // R6: a mask write lands on the next clock
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK) |=> (mask_q == $past(wdata[N_SRC-1:0])));

    // R7: any other access leaves the mask alone
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
// Module irq_prio_enc
// Combinational lowest-index-first priority encoder. Reports whether any
// bit is set and the index of the lowest set bit. Assumes N >= 1.
module irq_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2((N > 1) ? N : 2)
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is written last
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_top.sv
`timescale 1ns/1ps
// Module irq_vector_top
// Masked interrupt encoder: level sources, software enable mask, one
// registered combined request, and a register port whose vector read
// returns (lowest pending index + 1) * 4. Assumes 16-bit register
// accesses and inputs synchronous to clk; reset is synchronous, active low.
module irq_vector_top #(
    parameter int          N_SRC      = 16,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 12,
    parameter logic [15:0] MASK_RESET = irq_pkg::MASK_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_lvl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);

    localparam int IDX_W = $clog2((N_SRC > 1) ? N_SRC : 2);
    localparam int VEC_W = $clog2(N_SRC + 1) + irq_pkg::VEC_SHIFT;
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(irq_pkg::OFS_VEC);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(irq_pkg::OFS_MASK);

    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mask_nxt;
    logic [N_SRC-1:0] pend;
    logic             pend_hit;
    logic [IDX_W-1:0] pend_idx;
    logic [VEC_W-1:0] vec;
    logic             irq_q;

    irq_src_capture #(.N_SRC(N_SRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_lvl (irq_lvl),
        .src_q   (src_q)
    );

    irq_mask_reg #(
        .N_SRC      (N_SRC),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .MASK_RESET (MASK_RESET)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    // Pending set: captured sources gated by the current mask
    assign pend = src_q & mask_q;

    irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_enc (
        .req (pend),
        .hit (pend_hit),
        .idx (pend_idx)
    );

    // Vector code: (index + 1) shifted left, zero when nothing pends
    always_comb begin
        if (pend_hit)
            vec = (VEC_W'(pend_idx) + VEC_W'(1)) << irq_pkg::VEC_SHIFT;
        else
            vec = '0;
    end

    // Combined request flop, fed from next-state sources and mask
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(irq_lvl & mask_nxt);
    end

    assign irq_out = irq_q;

    // Read mux: vector, mask, or zero for unused offsets
    always_comb begin
        rdata = '0;
        if (addr == A_VEC)
            rdata[VEC_W-1:0] = vec;
        else if (addr == A_MASK)
            rdata[N_SRC-1:0] = mask_q;
    end

    // R3: request flop agrees with the registered sources and mask
    a_r3_out_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(src_q & mask_q)));

    // R4: any pending source gives a nonzero, word-aligned vector
    a_r4_vec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_VEC && (|(src_q & mask_q))) |->
            (rdata != '0 && rdata[1:0] == 2'b00));

    // R5: nothing pending reads as zero
    a_r5_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_VEC && !(|(src_q & mask_q))) |-> (rdata == '0));

    // R8: unused offsets read as zero
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != A_VEC && addr != A_MASK) |-> (rdata == '0));

endmodule

// File: tb/irq_vector_top_test.sv
`timescale 1ns/1ps
// Bench for irq_vector_top: a behavioural reference model advanced on
// every clock and compared with the outputs both before and after each edge.
module irq_vector_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lvl = '0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_src;
    logic [15:0] m_mask;
    logic        m_out;

    always #5 clk = ~clk;

    irq_vector_top uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_lvl (irq_lvl),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    function automatic logic [15:0] m_read(logic [11:0] a);
        logic [15:0] p;
        p = m_src & m_mask;
        if (a == 12'h000) begin
            for (int k = 0; k < 16; k++)
                if (p[k]) return 16'((k + 1) * 4);
            return 16'h0000;
        end
        if (a == 12'h002) return m_mask;
        return 16'h0000;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, check old state, clock, advance model, check
    task automatic tick(string tag, logic [15:0] lv, logic w,
                        logic [11:0] a, logic [15:0] d);
        irq_lvl = lv; wr_en = w; addr = a; wdata = d;
        #1;
        chk({tag, " pre-edge out"}, {15'b0, irq_out}, {15'b0, m_out});
        chk({tag, " pre-edge rdata"}, rdata, m_read(a));
        @(posedge clk);
        m_src = lv;
        if (w && a == 12'h002) m_mask = d;
        m_out = (m_src & m_mask) != 16'h0;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " out"}, {15'b0, irq_out}, {15'b0, m_out});
        chk({tag, " rdata"}, rdata, m_read(a));
    endtask

    task automatic rd(string tag, logic [11:0] a, logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [5] = '{12'h000, 12'h002, 12'h004, 12'h001, 12'h002};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_src = '0; m_mask = 16'h0010; m_out = 1'b0;

        // R1: reset state
        rd("R1 mask reset", 12'h002, 16'h0010);
        rd("R1 vector reset", 12'h000, 16'h0000);
        chk("R1 irq_out reset", {15'b0, irq_out}, 16'h0);

        // R2/R3/R4: enabled source 4 rises, vector (4+1)*4 = 20
        tick("R2 R3 R4 rise", 16'h0010, 0, 12'h000, 0);
        chk("R4 vector idx4", rdata, 16'd20);
        // R5: masked source only, vector 0 and output low
        tick("R5 masked", 16'h0008, 0, 12'h000, 0);
        chk("R5 masked vector", rdata, 16'd0);
        // R6: open the mask, source 3 becomes pending, vector 16
        tick("R6 mask write", 16'h0008, 1, 12'h002, 16'hFFFF);
        rd("R6 mask readback", 12'h002, 16'hFFFF);
        tick("R4 idx3", 16'h0008, 0, 12'h000, 0);
        chk("R4 vector idx3", rdata, 16'd16);
        // R9: several pending, lowest index wins
        tick("R9 multi", 16'h8020, 0, 12'h000, 0);
        chk("R9 vector idx5", rdata, 16'd24);
        tick("R9 top only", 16'h8000, 0, 12'h000, 0);
        chk("R9 vector idx15", rdata, 16'd64);
        tick("R9 all", 16'hFFFF, 0, 12'h000, 0);
        chk("R9 vector idx0", rdata, 16'd4);
        // R6: mask cleared drops output next clock while lines stay high
        tick("R6 mask zero", 16'hFFFF, 1, 12'h002, 16'h0000);
        chk("R6 out low", {15'b0, irq_out}, 16'h0);
        // R2: falling line clears its bit
        tick("R6 reopen", 16'h0004, 1, 12'h002, 16'h0004);
        tick("R2 fall", 16'h0000, 0, 12'h000, 0);
        chk("R2 cleared vector", rdata, 16'd0);
        // R7: writes elsewhere ignored
        tick("R7 wr 0x000", 16'h0000, 1, 12'h000, 16'hAAAA);
        tick("R7 wr 0x001", 16'h0000, 1, 12'h001, 16'hBBBB);
        tick("R7 wr 0x003", 16'h0000, 1, 12'h003, 16'hCCCC);
        tick("R7 wr 0x004", 16'h0000, 1, 12'h004, 16'hDDDD);
        rd("R7 mask unchanged", 12'h002, 16'h0004);
        // R8: unused offsets read 0
        tick("R8 setup", 16'h0004, 0, 12'h000, 0);
        rd("R8 read 0x004", 12'h004, 16'h0000);
        rd("R8 read 0x001", 12'h001, 16'h0000);
        rd("R8 read 0x0FE", 12'h0FE, 16'h0000);

        // R3: random traffic against the model
        for (int i = 0; i < 400; i++) begin
            tick("R3 random", 16'($urandom), ($urandom % 4) == 0,
                 offs[$urandom % 5], 16'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule